// File: doc/BRIEF.md
# Unaligned Bit-Field Register ALU

This block is a datapath that holds a small file of general-purpose registers and applies one arithmetic or logic operation to bit fields placed at any offset inside those registers. A command names two registers, a bit offset in each, one field width and an opcode. The block pulls a field of that width out of each operand, combines the two fields, and writes the result back into the first operand's field. Every other bit of the destination register keeps its value.

A field does not have to fit inside one register. When offset plus width goes past the top bit, the field carries on in the low bits of the next higher register. Such a field is read and written in the same cycle as a field that fits, so software can walk packed records whose items straddle word boundaries without shifting and masking by hand. A load port fills registers from the memory side. A read port returns the contents of any register.

Top module: `bfalu_top`

## Requirements
- R1: After a synchronous active-low reset, all twelve 16-bit registers read 0, `cmd_err` is 0 and `cmd_ready` is 1.
- R2: While `ld_en` is 1, the register `ld_addr` (0 to 11) takes `ld_data` at the clock edge, and `cmd_ready` is 0, so a command offered in that cycle is not taken and changes no register.
- R3: An accepted legal command reads a field of `cmd_width` bits starting at bit `cmd_offa` of register `cmd_ra` and the same width starting at bit `cmd_offb` of `cmd_rb`. It writes the result into the first field. Destination bits outside the field are unchanged. Example: adding 2 to a 7-bit field at bits 3 to 9 leaves bits 0 to 2 and 10 to 15 as they were.
- R4: If offset plus width is greater than 16, the field continues into bit 0 upward of the next higher register, with the same latency. No register other than the destination (and the next register when the field spans) changes.
- R5: Results wrap modulo 2^width. A carry or borrow out of the field never reaches a neighbouring bit.
- R6: The opcode `cmd_op` is decoded as follows, where A is the first field and B the second: 0 gives A+B, 1 gives A−B, 2 gives A shifted left by B, 3 gives A shifted right logically by B, 4 gives A AND B, 5 gives A OR B, 6 gives A XOR B, 7 copies B. Bits shifted out of the field are lost, and a shift of 16 or more gives 0.
- R7: A command is illegal if its width is 0 or above 16, if either register number is above 11, or if either field would run past register 11. An accepted illegal command writes nothing, and `cmd_err` is 1 in the following cycle only.
- R8: `cmd_ready` is 1 whenever `ld_en` is 0. The write-back of an accepted command is visible in the next cycle. Back-to-back commands each see the result of the one before.
- R9: `rd_data` shows register `rd_addr` combinationally, and shows 0 for an address above 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 3 | Operation code |
| cmd_ra | input | 4 | First operand register, also the destination |
| cmd_offa | input | 4 | Bit offset of the first field |
| cmd_rb | input | 4 | Second operand register |
| cmd_offb | input | 4 | Bit offset of the second field |
| cmd_width | input | 5 | Field width for both operands and the result |
| cmd_err | output | 1 | Previous accepted command was illegal |
| ld_en | input | 1 | Load a register |
| ld_addr | input | 4 | Register to load |
| ld_data | input | 16 | Value to load |
| rd_addr | input | 4 | Register to read |
| rd_data | output | 16 | Contents of `rd_addr` |

## Verification
A table of commands covers every opcode. The fields are placed at offset 0, at interior offsets and at offset 15. The neighbouring bits are filled with ones or with mixed patterns, so any leak from the mask or the insert logic shows up as a changed bit. One vector wraps a carry across the seam between two registers, and another gives a subtraction that underflows. Between them these tell a correct two-register splice apart from a carry that spills into a neighbour or a field truncated at bit 15. Directed cases place fields at the last-register boundary on both sides of legality, try bad widths and register numbers, and run commands back to back and commands that collide with a load, which tests the acceptance rules separately from the arithmetic.

// File: rtl/bfalu_pkg.sv
// Package bfalu_pkg
// Shared sizes, opcode encoding and the field-mask helper for the
// bit-field register ALU. Assumes WORD is a power of two.
package bfalu_pkg;
    parameter int unsigned WORD = 16;
    parameter int unsigned NREG = 12;
    localparam int unsigned RIDX_W = $clog2(NREG) + ((NREG <= 1) ? 1 : 0);
    localparam int unsigned OFF_W  = $clog2(WORD);
    localparam int unsigned WID_W  = $clog2(WORD) + 1;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_SHL = 3'd2,
        OP_SHR = 3'd3,
        OP_AND = 3'd4,
        OP_OR  = 3'd5,
        OP_XOR = 3'd6,
        OP_MOV = 3'd7
    } bf_op_e;

    // Low w bits set; w == WORD gives all ones.
    function automatic logic [WORD-1:0] field_mask(input logic [WID_W-1:0] w);
        logic [WORD:0] t;
        t = ((WORD+1)'(1) << w) - (WORD+1)'(1);
        return t[WORD-1:0];
    endfunction
endpackage

// File: rtl/bf_extract.sv
// Module bf_extract
// Pulls a right-aligned field out of a two-register window {hi, lo}.
// Assumes off < WORD and 1 <= wid <= WORD; bits above wid come out 0.
module bf_extract
    import bfalu_pkg::*;
(
    input  logic [WORD-1:0]  lo,
    input  logic [WORD-1:0]  hi,
    input  logic [OFF_W-1:0] off,
    input  logic [WID_W-1:0] wid,
    output logic [WORD-1:0]  field
);
    logic [2*WORD-1:0] shifted;

    // Shift the window down to the offset, then mask to the width.
    always_comb begin
        shifted = {hi, lo} >> off;
        field   = shifted[WORD-1:0] & field_mask(wid);
    end
endmodule

// File: rtl/bf_alu.sv
// Module bf_alu
// Combines two right-aligned fields and wraps the result to the field
// width. Assumes the inputs are already masked to wid bits.
module bf_alu
    import bfalu_pkg::*;
(
    input  bf_op_e           op,
    input  logic [WORD-1:0]  a,
    input  logic [WORD-1:0]  b,
    input  logic [WID_W-1:0] wid,
    output logic [WORD-1:0]  res
);
    logic [WORD-1:0] raw;

    // Select the operation, then drop every bit above the width.
    always_comb begin
        unique case (op)
            OP_ADD: raw = a + b;
            OP_SUB: raw = a - b;
            OP_SHL: raw = (b >= WORD) ? '0 : (a << b[OFF_W-1:0]);
            OP_SHR: raw = (b >= WORD) ? '0 : (a >> b[OFF_W-1:0]);
            OP_AND: raw = a & b;
            OP_OR:  raw = a | b;
            OP_XOR: raw = a ^ b;
            default: raw = b;
        endcase
        res = raw & field_mask(wid);
    end
endmodule

// File: rtl/bf_insert.sv
// Module bf_insert
// Splices a right-aligned value into a two-register window at a bit
// offset, keeping all other bits. Assumes val has no bits above wid.
module bf_insert
    import bfalu_pkg::*;
(
    input  logic [WORD-1:0]  lo,
    input  logic [WORD-1:0]  hi,
    input  logic [OFF_W-1:0] off,
    input  logic [WID_W-1:0] wid,
    input  logic [WORD-1:0]  val,
    output logic [WORD-1:0]  new_lo,
    output logic [WORD-1:0]  new_hi
);
    logic [2*WORD-1:0] win_mask;
    logic [2*WORD-1:0] merged;

    // Clear the field in the window and OR in the shifted value.
    always_comb begin
        win_mask = {{WORD{1'b0}}, field_mask(wid)} << off;
        merged   = ({hi, lo} & ~win_mask) | (({{WORD{1'b0}}, val} << off) & win_mask);
        new_lo   = merged[WORD-1:0];
        new_hi   = merged[2*WORD-1:WORD];
    end
endmodule

// File: rtl/bfalu_top.sv
// Module bfalu_top
// Register file with a bit-field ALU. It takes one command per cycle
// unless a load is in progress, and a field may straddle two registers.
// Assumes synchronous active-low reset; the load port has priority.
module bfalu_top
    import bfalu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [RIDX_W-1:0] cmd_ra,
    input  logic [OFF_W-1:0]  cmd_offa,
    input  logic [RIDX_W-1:0] cmd_rb,
    input  logic [OFF_W-1:0]  cmd_offb,
    input  logic [WID_W-1:0]  cmd_width,
    output logic              cmd_err,
    input  logic              ld_en,
    input  logic [RIDX_W-1:0] ld_addr,
    input  logic [WORD-1:0]   ld_data,
    input  logic [RIDX_W-1:0] rd_addr,
    output logic [WORD-1:0]   rd_data
);
    localparam int unsigned SUM_W = WID_W + 1;

    logic [WORD-1:0]   rf [NREG];
    logic [RIDX_W:0]   idx_lo [2];
    logic [RIDX_W:0]   idx_hi [2];
    logic [OFF_W-1:0]  off    [2];
    logic [WORD-1:0]   win_lo [2];
    logic [WORD-1:0]   win_hi [2];
    logic [WORD-1:0]   fld    [2];
    logic [1:0]        spans;
    logic [1:0]        bad;
    logic              wid_ok, legal, acc, wr_go;
    logic [WORD-1:0]   res, new_lo, new_hi;

    assign cmd_ready = !ld_en;
    assign acc       = cmd_valid && cmd_ready;
    assign idx_lo[0] = {1'b0, cmd_ra};
    assign idx_lo[1] = {1'b0, cmd_rb};
    assign off[0]    = cmd_offa;
    assign off[1]    = cmd_offb;
    assign wid_ok    = (cmd_width != '0) && (cmd_width <= WID_W'(WORD));

    // Per operand: window fetch, span and range check, field extraction.
    for (genvar g = 0; g < 2; g++) begin : g_opnd
        assign idx_hi[g] = idx_lo[g] + 1'b1;
        assign spans[g]  = (SUM_W'(off[g]) + SUM_W'(cmd_width)) > SUM_W'(WORD);
        assign bad[g]    = (idx_lo[g] >= (RIDX_W+1)'(NREG)) ||
                           (spans[g] && (idx_hi[g] >= (RIDX_W+1)'(NREG)));

        // Read both registers of the window; missing ones read as zero.
        always_comb begin
            win_lo[g] = '0;
            win_hi[g] = '0;
            for (int i = 0; i < NREG; i++) begin
                if (idx_lo[g] == (RIDX_W+1)'(i)) win_lo[g] = rf[i];
                if (idx_hi[g] == (RIDX_W+1)'(i)) win_hi[g] = rf[i];
            end
        end

        bf_extract u_ext (
            .lo(win_lo[g]), .hi(win_hi[g]), .off(off[g]),
            .wid(cmd_width), .field(fld[g])
        );
    end

    assign legal = wid_ok && (bad == 2'b00);
    assign wr_go = acc && legal;

    bf_alu u_alu (
        .op(bf_op_e'(cmd_op)), .a(fld[0]), .b(fld[1]),
        .wid(cmd_width), .res(res)
    );

    bf_insert u_ins (
        .lo(win_lo[0]), .hi(win_hi[0]), .off(cmd_offa), .wid(cmd_width),
        .val(res), .new_lo(new_lo), .new_hi(new_hi)
    );

    // Register update: reset, then load, then command write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) rf[i] <= '0;
            cmd_err <= 1'b0;
        end else begin
            cmd_err <= acc && !legal;
            for (int i = 0; i < NREG; i++) begin
                if (ld_en && ld_addr == RIDX_W'(i))
                    rf[i] <= ld_data;
                else if (wr_go && idx_lo[0] == (RIDX_W+1)'(i))
                    rf[i] <= new_lo;
                else if (wr_go && spans[0] && idx_hi[0] == (RIDX_W+1)'(i))
                    rf[i] <= new_hi;
            end
        end
    end

    // Read port: direct view of one register, zero when out of range.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++)
            if (rd_addr == RIDX_W'(i)) rd_data = rf[i];
    end

    // ---------------- assertions ----------------
    logic [NREG*WORD-1:0] rf_flat;
    logic [WORD-1:0]      keep_lo;

    for (genvar g = 0; g < NREG; g++) begin : g_flat
        assign rf_flat[g*WORD +: WORD] = rf[g];
    end
    assign keep_lo = ~WORD'({{WORD{1'b0}}, field_mask(cmd_width)} << cmd_offa);

    for (genvar g = 0; g < NREG; g++) begin : g_chk
        // R2: a load lands in its register.
        p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (ld_en && ld_addr == RIDX_W'(g)) |=> rf[g] == $past(ld_data));
        // R3: destination bits outside the field keep their value.
        p_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_go && !ld_en && cmd_ra == RIDX_W'(g)) |=>
            ((rf[g] ^ $past(rf[g])) & $past(keep_lo)) == '0);
        // R4: registers not targeted by a load or a write-back stay put.
        p_untouched_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!(ld_en && ld_addr == RIDX_W'(g)) &&
             !(wr_go && (cmd_ra == RIDX_W'(g) ||
                         (spans[0] && idx_hi[0] == (RIDX_W+1)'(g))))) |=>
            $stable(rf[g]));
    end

    // R7: an illegal command raises the error flag and writes nothing.
    p_illegal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !legal) |=> (cmd_err && $stable(rf_flat)));
endmodule

// File: tb/sim_bfalu_top.sv
// Bench for bfalu_top: a vector table then directed corner cases.
module sim_bfalu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [2:0]  cmd_op = '0;
    logic [3:0]  cmd_ra = '0, cmd_offa = '0, cmd_rb = '0, cmd_offb = '0;
    logic [4:0]  cmd_width = '0;
    logic        cmd_err;
    logic        ld_en = 1'b0;
    logic [3:0]  ld_addr = '0;
    logic [15:0] ld_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bfalu_top u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_ra(cmd_ra), .cmd_offa(cmd_offa), .cmd_rb(cmd_rb),
        .cmd_offb(cmd_offb), .cmd_width(cmd_width), .cmd_err(cmd_err),
        .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic [3:0]  ra, oa, rb, ob;
        logic [4:0]  w;
        logic [15:0] va, va1, vb, ea, ea1;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 4'd2, 4'd3,  4'd5, 4'd0, 5'd7,  16'hA5A5, 16'h1234, 16'h0002, 16'hA5B5, 16'h1234},
        '{3'd0, 4'd2, 4'd0,  4'd5, 4'd0, 5'd4,  16'h00FF, 16'h1111, 16'h0003, 16'h00F2, 16'h1111},
        '{3'd0, 4'd2, 4'd12, 4'd5, 4'd0, 5'd8,  16'hF000, 16'h0005, 16'h0001, 16'h0000, 16'h0006},
        '{3'd1, 4'd2, 4'd4,  4'd5, 4'd8, 5'd8,  16'h0030, 16'hBEEF, 16'h0500, 16'h0FE0, 16'hBEEF},
        '{3'd2, 4'd2, 4'd0,  4'd5, 4'd0, 5'd8,  16'hAB81, 16'h2222, 16'h0002, 16'hAB04, 16'h2222},
        '{3'd3, 4'd2, 4'd8,  4'd5, 4'd4, 5'd8,  16'hF0AA, 16'h3333, 16'h0040, 16'h0FAA, 16'h3333},
        '{3'd4, 4'd2, 4'd0,  4'd5, 4'd0, 5'd16, 16'h1234, 16'h5555, 16'h0FF0, 16'h0230, 16'h5555},
        '{3'd5, 4'd2, 4'd2,  4'd5, 4'd0, 5'd3,  16'h0000, 16'h6666, 16'h0005, 16'h0014, 16'h6666},
        '{3'd6, 4'd2, 4'd15, 4'd5, 4'd0, 5'd2,  16'h8000, 16'h0001, 16'h0001, 16'h0000, 16'h0001},
        '{3'd7, 4'd2, 4'd5,  4'd5, 4'd4, 5'd6,  16'hFFFF, 16'h7777, 16'hABCD, 16'hFF9F, 16'h7777},
        '{3'd2, 4'd2, 4'd0,  4'd5, 4'd0, 5'd4,  16'h000F, 16'h8888, 16'h0005, 16'h0000, 16'h8888}
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic read_reg(input logic [3:0] a, output logic [15:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic load(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // Offer one command for exactly one cycle; returns at the next negedge.
    task automatic issue(input logic [2:0] op, input logic [3:0] ra, input logic [3:0] oa,
                         input logic [3:0] rb, input logic [3:0] ob, input logic [4:0] w);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_ra = ra; cmd_offa = oa;
        cmd_rb = rb; cmd_offb = ob; cmd_width = w;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1 cmd_err", {15'd0, cmd_err}, 16'd0);
        check("R1 cmd_ready", {15'd0, cmd_ready}, 16'd1);
        for (int i = 0; i < 12; i++) begin
            read_reg(4'(i), v);
            check("R1 register zero", v, 16'h0000);
        end

        load(4'd8, 16'h5A5A);

        // Vector table: R3 R4 R5 R6
        for (int k = 0; k < NV; k++) begin
            load(VEC[k].ra, VEC[k].va);
            load(VEC[k].ra + 4'd1, VEC[k].va1);
            load(VEC[k].rb, VEC[k].vb);
            issue(VEC[k].op, VEC[k].ra, VEC[k].oa, VEC[k].rb, VEC[k].ob, VEC[k].w);
            read_reg(VEC[k].ra, v);
            check($sformatf("R3 R5 R6 vector %0d dest", k), v, VEC[k].ea);
            read_reg(VEC[k].ra + 4'd1, v);
            check($sformatf("R4 vector %0d next reg", k), v, VEC[k].ea1);
            check($sformatf("R7 vector %0d no error", k), {15'd0, cmd_err}, 16'd0);
        end
        read_reg(4'd8, v);
        check("R4 bystander register", v, 16'h5A5A);

        // R7: illegal commands
        load(4'd10, 16'h4321);
        load(4'd11, 16'h1234);
        issue(3'd0, 4'd11, 4'd10, 4'd10, 4'd0, 5'd8);
        check("R7 span past last reg flag", {15'd0, cmd_err}, 16'd1);
        read_reg(4'd11, v);
        check("R7 span past last reg no write", v, 16'h1234);
        @(negedge clk);
        check("R7 flag one cycle", {15'd0, cmd_err}, 16'd0);
        issue(3'd0, 4'd10, 4'd0, 4'd11, 4'd0, 5'd0);
        check("R7 width zero flag", {15'd0, cmd_err}, 16'd1);
        read_reg(4'd10, v);
        check("R7 width zero no write", v, 16'h4321);
        issue(3'd0, 4'd12, 4'd0, 4'd10, 4'd0, 5'd4);
        check("R7 bad register flag", {15'd0, cmd_err}, 16'd1);
        issue(3'd7, 4'd10, 4'd0, 4'd11, 4'd12, 5'd8);
        check("R7 second field past end flag", {15'd0, cmd_err}, 16'd1);
        read_reg(4'd10, v);
        check("R7 second field past end no write", v, 16'h4321);
        issue(3'd0, 4'd10, 4'd0, 4'd11, 4'd0, 5'd17);
        check("R7 width 17 flag", {15'd0, cmd_err}, 16'd1);
        // Legal at the boundary: full word in the last register
        issue(3'd0, 4'd11, 4'd0, 4'd10, 4'd0, 5'd16);
        check("R7 last reg legal no flag", {15'd0, cmd_err}, 16'd0);
        read_reg(4'd11, v);
        check("R7 last reg legal result", v, 16'h5555);

        // R9: out-of-range read
        read_reg(4'd13, v);
        check("R9 read out of range", v, 16'h0000);

        // R2: load blocks a concurrent command
        @(negedge clk);
        ld_en = 1'b1; ld_addr = 4'd0; ld_data = 16'h1111;
        cmd_valid = 1'b1; cmd_op = 3'd7; cmd_ra = 4'd1; cmd_offa = 4'd0;
        cmd_rb = 4'd8; cmd_offb = 4'd0; cmd_width = 5'd16;
        #1;
        check("R2 ready low during load", {15'd0, cmd_ready}, 16'd0);
        @(negedge clk);
        ld_en = 1'b0; cmd_valid = 1'b0;
        read_reg(4'd0, v);
        check("R2 load written", v, 16'h1111);
        read_reg(4'd1, v);
        check("R2 blocked command ignored", v, 16'h0000);

        // R8: back-to-back accumulate R1 += R0
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd0; cmd_ra = 4'd1; cmd_offa = 4'd0;
        cmd_rb = 4'd0; cmd_offb = 4'd0; cmd_width = 5'd16;
        #1;
        check("R8 ready when idle", {15'd0, cmd_ready}, 16'd1);
        @(negedge clk);
        read_reg(4'd1, v);
        check("R8 first result next cycle", v, 16'h1111);
        @(negedge clk);
        cmd_valid = 1'b0;
        read_reg(4'd1, v);
        check("R8 second sees first", v, 16'h2222);

        finish_run();
    end
endmodule